// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block produces the active-low system reset for a chip region from two conditions. The first is a level from an undervoltage comparator, already digitized and already hysteretic. The second is a manual reset request. Both inputs arrive asynchronously and are brought into the clock domain with synchronizer stages. The manual request must also stay high for a minimum number of cycles before it counts, so short glitches on a long wire are filtered out.

Reset is driven low one register stage after either condition is seen. It is released only after a quiet period. That period starts when both conditions have cleared. It is counted on a free-running clock, and its length is chosen from three options by a select input. Any return of either condition during the quiet period clears the count, so the full period is needed again. The select input is captured only while a hold condition is present, which means a delay already in progress cannot be lengthened or shortened.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst` is high, `rst_n_o` is low. The delay length is captured from `dly_sel_i` during `rst`. After `rst` falls with no condition present, `rst_n_o` rises exactly that many cycles later.
- R2: A high on `uv_lvl_i` drives `rst_n_o` low on the third rising edge after the change: two synchronizer stages plus the output register. No timer is involved.
- R3: After `uv_lvl_i` falls, with no manual request held, `rst_n_o` rises on the (L+2)-th rising edge, where L is the selected delay count.
- R4: `dly_sel_i` encoding: 0 selects `DLY_SHORT`, 1 selects `DLY_MID`, and 2 or 3 select `DLY_LONG`.
- R5: A manual request held high for `MR_FILT` or more cycles drives `rst_n_o` low `MR_FILT+3` edges after it rises. A request shorter than `MR_FILT` cycles leaves `rst_n_o` high.
- R6: After a qualified manual request falls, `rst_n_o` rises on the (L+3)-th rising edge.
- R7: If either condition returns while the delay is counting, the count is cleared. The full L cycles are then counted again from the latest clearing.
- R8: `dly_sel_i` is captured only while a hold condition is present. A change during the delay does not alter the release time.
- R9: While either condition holds, `rst_n_o` stays low. With both conditions present, release waits for the later of the two to clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that times the delay |
| rst | input | 1 | Synchronous active-high initialization |
| uv_lvl_i | input | 1 | Comparator level, 1 = supply below threshold (asynchronous) |
| mr_req_i | input | 1 | Manual reset request, active high (asynchronous) |
| dly_sel_i | input | 2 | Release delay choice, encoded as in R4 |
| rst_n_o | output | 1 | System reset, low = asserted |

## Verification
Each result has a fixed latency, counted in rising edges from the edge after the input change:
- Undervoltage assertion lands on edge 3.
- Manual assertion lands on edge `MR_FILT+3`.
- Release lands on edge L+2 after undervoltage recovery and on edge L+3 after a manual request falls.

The bench drives every input on a falling edge and steps the clock one falling edge at a time. It checks the output at the edge one before and at the edge where each transition is due, so an error of a single cycle in either direction is reported. The filter boundary is checked with pulses of exactly `MR_FILT-1` and `MR_FILT` cycles, and restart and select-freezing are checked by the exact release edge.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

    typedef enum logic [1:0] {
        SEL_SHORT    = 2'd0,
        SEL_MID      = 2'd1,
        SEL_LONG     = 2'd2,
        SEL_LONG_ALT = 2'd3
    } dly_sel_e;

    typedef struct packed {
        logic uv;
        logic mr;
    } hold_src_t;

    function automatic int unsigned pick_delay(input dly_sel_e sel,
                                               input int unsigned d_short,
                                               input int unsigned d_mid,
                                               input int unsigned d_long);
        case (sel)
            SEL_SHORT: return d_short;
            SEL_MID:   return d_mid;
            default:   return d_long;
        endcase
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/srs_pulse_filter.sv
module srs_pulse_filter #(
    parameter int MR_FILT = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int CW = $clog2(MR_FILT + 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !d) begin
            run <= '0;
            q   <= 1'b0;
        end else if (run == CW'(MR_FILT - 1)) begin
            q   <= 1'b1;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/srs_delay_timer.sv
module srs_delay_timer
    import supply_reset_pkg::*;
#(
    parameter int unsigned DLY_SHORT = 10000000,
    parameter int unsigned DLY_MID   = 20000000,
    parameter int unsigned DLY_LONG  = 40000000,
    parameter int          CNT_W     = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_i,
    input  dly_sel_e         sel_i,
    output logic [CNT_W-1:0] lim_o,
    output logic             rst_n_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            cnt     <= '0;
            rst_n_o <= 1'b0;
            lim     <= CNT_W'(pick_delay(sel_i, DLY_SHORT, DLY_MID, DLY_LONG));
        end else if (!rst_n_o) begin
            if (cnt == lim - 1'b1) rst_n_o <= 1'b1;
            else                   cnt     <= cnt + 1'b1;
        end
    end

    assign lim_o = lim;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import supply_reset_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          MR_FILT     = 3000,
    parameter int unsigned DLY_SHORT   = 10000000,
    parameter int unsigned DLY_MID     = 20000000,
    parameter int unsigned DLY_LONG    = 40000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       uv_lvl_i,
    input  logic       mr_req_i,
    input  logic [1:0] dly_sel_i,
    output logic       rst_n_o
);
    localparam int CNT_W = $clog2(DLY_LONG + 1);

    logic             uv_s;
    logic             mr_s;
    logic             mr_ok;
    logic             hold;
    hold_src_t        src;
    logic [CNT_W-1:0] lim;

    srs_sync #(.STAGES(SYNC_STAGES)) u_uv_sync (
        .clk(clk), .rst(rst), .d(uv_lvl_i), .q(uv_s)
    );

    srs_sync #(.STAGES(SYNC_STAGES)) u_mr_sync (
        .clk(clk), .rst(rst), .d(mr_req_i), .q(mr_s)
    );

    srs_pulse_filter #(.MR_FILT(MR_FILT)) u_mr_filt (
        .clk(clk), .rst(rst), .d(mr_s), .q(mr_ok)
    );

    assign src.uv = uv_s;
    assign src.mr = mr_ok;
    assign hold   = |src;

    srs_delay_timer #(
        .DLY_SHORT(DLY_SHORT), .DLY_MID(DLY_MID), .DLY_LONG(DLY_LONG), .CNT_W(CNT_W)
    ) u_timer (
        .clk(clk), .rst(rst), .hold_i(hold), .sel_i(dly_sel_e'(dly_sel_i)),
        .lim_o(lim), .rst_n_o(rst_n_o)
    );
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk #(
    parameter int MR_FILT = 3000,
    parameter int CNT_W   = 26
) (
    input logic             clk,
    input logic             rst,
    input logic             hold,
    input logic             mr_s,
    input logic             mr_ok,
    input logic [CNT_W-1:0] lim,
    input logic             rst_n_o
);
    logic [31:0] quiet_run;
    logic [31:0] mr_run;

    always_ff @(posedge clk) begin
        if (rst || hold || rst_n_o) quiet_run <= '0;
        else                        quiet_run <= quiet_run + 1;
        if (rst || !mr_s)           mr_run <= '0;
        else if (mr_run != '1)      mr_run <= mr_run + 1;
    end

    // R1: initialization holds reset asserted
    assert_reset_state_R1: assert property (@(posedge clk) rst |=> !rst_n_o);

    // R2 and R9: any hold condition forces the output low
    assert_hold_forces_low_R2: assert property (@(posedge clk) disable iff (rst)
        hold |=> !rst_n_o);

    // R3 and R7: release only after a full quiet run of the latched length
    assert_release_after_delay_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> (quiet_run == 32'(lim)));

    // R5: qualified manual request only after MR_FILT high cycles
    assert_mr_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mr_ok) |-> (mr_run >= 32'(MR_FILT)));

    // R8: limit frozen while no hold condition is present
    assert_limit_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !hold |=> $stable(lim));
endmodule

bind supply_reset_seq supply_reset_seq_chk #(.MR_FILT(MR_FILT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .hold(hold), .mr_s(mr_s), .mr_ok(mr_ok),
    .lim(lim), .rst_n_o(rst_n_o)
);

// File: tb/supply_reset_seq_test.sv
`timescale 1ns/100ps
module supply_reset_seq_test;
    localparam int FILT = 6;
    localparam int D0   = 20;
    localparam int D1   = 40;
    localparam int D2   = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uv  = 1'b0;
    logic       mr  = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       out;
    int         n_chk  = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    supply_reset_seq #(
        .MR_FILT(FILT), .DLY_SHORT(D0), .DLY_MID(D1), .DLY_LONG(D2)
    ) uut (
        .clk(clk), .rst(rst), .uv_lvl_i(uv), .mr_req_i(mr),
        .dly_sel_i(sel), .rst_n_o(out)
    );

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'd0:    return D0;
            2'd1:    return D1;
            default: return D2;
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic t_power_up();
        step(3);
        chk("R1 asserted during init", out, 1'b0);
        rst = 1'b0;
        step(D0 - 1);
        chk("R1 still low one before release", out, 1'b0);
        step(1);
        chk("R1 released after short delay", out, 1'b1);
    endtask

    task automatic t_uv_cycle(input logic [1:0] s);
        int l;
        l   = lim_of(s);
        uv  = 1'b1;
        sel = s;
        step(2);
        chk("R2 not yet low at edge 2", out, 1'b1);
        step(1);
        chk("R2 low at edge 3", out, 1'b0);
        step(5);
        uv = 1'b0;
        step(l + 1);
        chk("R3 R4 low one before release", out, 1'b0);
        step(1);
        chk("R3 R4 released at L+2", out, 1'b1);
    endtask

    task automatic t_mr_short();
        int lows;
        lows = 0;
        mr   = 1'b1;
        step(FILT - 1);
        mr = 1'b0;
        for (int i = 0; i < FILT + 10; i++) begin
            step(1);
            if (out !== 1'b1) lows++;
        end
        chk("R5 short manual pulse ignored", lows == 0, 1'b1);
    endtask

    task automatic t_mr_exact();
        int l;
        l  = lim_of(sel);
        mr = 1'b1;
        step(FILT);
        mr = 1'b0;
        step(2);
        chk("R5 exact width not yet low", out, 1'b1);
        step(1);
        chk("R5 exact width asserts", out, 1'b0);
        step(l - 1);
        chk("R6 exact pulse low one before release", out, 1'b0);
        step(1);
        chk("R6 exact pulse released", out, 1'b1);
    endtask

    task automatic t_mr_long();
        int l;
        l  = lim_of(sel);
        mr = 1'b1;
        step(FILT + 2);
        chk("R5 long request not yet low", out, 1'b1);
        step(1);
        chk("R5 long request low at FILT+3", out, 1'b0);
        step(4);
        mr = 1'b0;
        step(l + 2);
        chk("R6 low one before release", out, 1'b0);
        step(1);
        chk("R6 released at L+3", out, 1'b1);
    endtask

    task automatic t_restart();
        int l;
        l  = lim_of(sel);
        uv = 1'b1;
        step(5);
        uv = 1'b0;
        step(l / 2);
        chk("R7 mid delay still low", out, 1'b0);
        uv = 1'b1;
        step(1);
        uv = 1'b0;
        step(l + 1);
        chk("R7 full delay restarted", out, 1'b0);
        step(1);
        chk("R7 release L+2 after latest clear", out, 1'b1);
    endtask

    task automatic t_sel_freeze();
        int l;
        sel = 2'd0;
        l   = lim_of(2'd0);
        uv  = 1'b1;
        step(5);
        uv = 1'b0;
        step(3);
        sel = 2'd2;
        step(l + 1 - 3);
        chk("R8 low one before original release", out, 1'b0);
        step(1);
        chk("R8 select change mid delay ignored", out, 1'b1);
        sel = 2'd0;
    endtask

    task automatic t_overlap();
        int l;
        l  = lim_of(sel);
        uv = 1'b1;
        mr = 1'b1;
        step(FILT + 5);
        chk("R9 both conditions hold low", out, 1'b0);
        uv = 1'b0;
        step(l + 10);
        chk("R9 manual still held keeps low", out, 1'b0);
        mr = 1'b0;
        step(l + 2);
        chk("R9 low until later clear plus delay", out, 1'b0);
        step(1);
        chk("R9 released after later condition", out, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        t_power_up();
        for (int s = 0; s < 4; s++) t_uv_cycle(2'(s));
        sel = 2'd0;
        t_mr_short();
        t_mr_exact();
        t_mr_long();
        t_restart();
        t_sel_freeze();
        sel = 2'd1;
        t_overlap();
        summary();
        $finish;
    end
endmodule